// File: doc/BRIEF.md
# Grouped Sensor Presence Classifier

This block watches five presence sensors and decides whether more than two distinct properties are being detected. A sensor bit of 1 means its sensor reports presence. The three low sensors each watch a property of their own. The two high sensors are redundant watchers of one shared property, so either or both of them being set adds exactly one property to the tally.

The decision is purely combinational on `quorum_o`. A registered copy, `quorum_q`, is provided for consumers that need a flopped signal. It loads on every rising clock edge and is cleared by a synchronous reset.

Top module: `sense_quorum`

## Requirements
- R1: `quorum_o` is 1 whenever `sense_i[2:0]` is 3'b111, whatever `sense_i[4:3]` holds (for example 5'b00111 gives 1).
- R2: With exactly two of `sense_i[2:0]` set, `quorum_o` is 1 when at least one of `sense_i[4]` or `sense_i[3]` is set.
- R3: `sense_i[4]` and `sense_i[3]` together add at most one property: with exactly one bit of `sense_i[2:0]` set and both high bits set, `quorum_o` is 0 (for example 5'b11010 gives 0).
- R4: With at most one bit of `sense_i[2:0]` set, `quorum_o` is 0 for every value of `sense_i[4:3]`.
- R5: With exactly two of `sense_i[2:0]` set and `sense_i[4:3]` equal to 2'b00, `quorum_o` is 0.
- R6: When `rst` is low at a rising edge of `clk`, `quorum_q` takes the value `quorum_o` had just before that edge.
- R7: When `rst` is high at a rising edge of `clk`, `quorum_q` becomes 0 after that edge, whatever `sense_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered copy |
| rst | input | 1 | Synchronous reset, active high |
| sense_i | input | 5 | Sensor vector; bits 2..0 are distinct properties, bits 4..3 share one property |
| quorum_o | output | 1 | Combinational decision: more than two distinct properties present |
| quorum_q | output | 1 | `quorum_o` registered on the rising edge |

## Verification
The block holds one flop, so a wrong state there can only show as `quorum_q` disagreeing with the decision the bench applied one edge earlier, or as a 1 surviving a reset edge; either appears on the very next rising edge. Decision errors are stateless and show on `quorum_o` within the same cycle, and the most telling one is a plain population count, which turns 5'b11010 and every other code with both high bits and one low bit into a false 1. All 32 codes are applied, so any miscounted grouping is exposed.

// File: rtl/sense_quorum.sv
module sense_quorum (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] sense_i,
  output logic       quorum_o,
  output logic       quorum_q
);
  localparam int LOW_W  = 3;
  localparam int NEED   = 3;

  logic [LOW_W-1:0] own_bits;
  logic             shared_hit;
  logic [1:0]       low_cnt;
  logic [2:0]       class_cnt;

  assign own_bits   = sense_i[LOW_W-1:0];
  assign shared_hit = sense_i[4] | sense_i[3];
  assign low_cnt    = {1'b0, own_bits[0]} + {1'b0, own_bits[1]} + {1'b0, own_bits[2]};
  assign class_cnt  = {1'b0, low_cnt} + {2'b00, shared_hit};
  assign quorum_o   = (class_cnt >= 3'(NEED));

  always_ff @(posedge clk) begin
    if (rst) quorum_q <= 1'b0;
    else     quorum_q <= quorum_o;
  end
endmodule

// File: rtl/sense_quorum_chk.sv
module sense_quorum_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] sense_i,
  input logic       quorum_o,
  input logic       quorum_q
);
  // R1
  all_own_chk: assert property (@(posedge clk) disable iff (rst)
    (sense_i[2:0] == 3'b111) |-> quorum_o);

  // R2
  pair_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (($countones(sense_i[2:0]) == 2) && (sense_i[4:3] != 2'b00)) |-> quorum_o);

  // R3
  shared_once_chk: assert property (@(posedge clk) disable iff (rst)
    (($countones(sense_i[2:0]) == 1) && (sense_i[4:3] == 2'b11)) |-> !quorum_o);

  // R4
  sparse_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(sense_i[2:0]) <= 1) |-> !quorum_o);

  // R5
  pair_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (($countones(sense_i[2:0]) == 2) && (sense_i[4:3] == 2'b00)) |-> !quorum_o);

  // R6
  reg_copy_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (quorum_q == $past(quorum_o)));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !quorum_q);
endmodule

bind sense_quorum sense_quorum_chk i_sense_quorum_chk (
  .clk      (clk),
  .rst      (rst),
  .sense_i  (sense_i),
  .quorum_o (quorum_o),
  .quorum_q (quorum_q)
);

// File: tb/test_sense_quorum.sv
`timescale 1ns/1ps
module test_sense_quorum;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] sense_i = 5'd0;
  logic       quorum_o;
  logic       quorum_q;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sense_quorum i_sense_quorum (
    .clk      (clk),
    .rst      (rst),
    .sense_i  (sense_i),
    .quorum_o (quorum_o),
    .quorum_q (quorum_q)
  );

  function automatic logic ref_quorum(input logic [4:0] s);
    int n;
    n = int'(s[0]) + int'(s[1]) + int'(s[2]) + int'(s[3] | s[4]);
    return n > 2;
  endfunction

  function automatic string req_of(input logic [4:0] s);
    int lo;
    lo = int'(s[0]) + int'(s[1]) + int'(s[2]);
    if (lo == 3) return "R1";
    if (lo == 2) return (s[4:3] != 2'b00) ? "R2" : "R5";
    if (lo == 1 && s[4:3] == 2'b11) return "R3";
    return "R4";
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input logic [4:0] s);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sense=%b actual=%b expected=%b", req, s, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] v);
    logic e;
    @(negedge clk);
    sense_i = v;
    e = ref_quorum(v);
    #1 check(req_of(v), quorum_o, e, v);
    @(posedge clk);
    #1 check("R6", quorum_q, e, v);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(posedge clk);
    #1 check("R7", quorum_q, 1'b0, sense_i);
    @(negedge clk);
    rst = 1'b0;

    apply(5'b00111);
    apply(5'b11010);
    apply(5'b11001);
    apply(5'b00011);
    apply(5'b01011);
    apply(5'b10110);
    apply(5'b11111);
    apply(5'b11000);

    for (int k = 0; k < 32; k++) apply(5'(k));

    for (int k = 0; k < 200; k++) apply(5'($urandom() & 32'h1f));

    apply(5'b00111);
    @(negedge clk);
    rst = 1'b1;
    sense_i = 5'b11111;
    @(posedge clk);
    #1 check("R7", quorum_q, 1'b0, sense_i);
    check("R1", quorum_o, 1'b1, sense_i);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1 check("R6", quorum_q, 1'b1, sense_i);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule